// File: doc/BRIEF.md
# Replication-Aware Victim Selector

This block chooses which way of one cache set to give up when a new line must be placed. The set belongs to a private cache that cooperates with neighbouring private caches. Each line carries a flag saying whether it is the only copy on the chip. The block prefers to evict a line that has another copy elsewhere. A line that is the only copy is kept on chip: it is pushed to a neighbour's cache, and it gets a limited number of such moves before it is written back to memory.

The surrounding controller drives the per-way valid flags, the LRU ranks and the only-copy flags, and pulses a select request. One cycle later the block returns the chosen way, a disposition code, and the remaining move count that travels with a spilled line. The block keeps a small move counter for each way itself. A fill, which may carry an incoming count from a neighbour, loads that counter. A hit on the way clears it.

Top module: `repl_victim_sel`

## Requirements
- R1: If any way is invalid, the lowest-numbered invalid way is chosen, with disposition 11 (free, nothing is evicted) and outgoing count 0.
- R2: When all ways are valid and at least one of them is a replicate (only-copy flag 0), a replicate is chosen, even if an only-copy line has a higher LRU rank.
- R3: Among several replicates, the one with the highest LRU rank is chosen. Rank 0 is most recently used and rank WAYS-1 is least recently used. Ranks are packed at bits [i*RW +: RW] for way i.
- R4: When every way is valid and is an only-copy line, the only-copy line with the highest LRU rank is chosen.
- R5: A replicate victim gets disposition 00 (drop) and outgoing count 0.
- R6: An only-copy victim whose way holds no armed count gets disposition 01 (spill to a neighbour) and outgoing count N_CHANCE.
- R7: An only-copy victim whose way holds an armed count c gets disposition 10 (write to memory) with count 0 when c-1 is zero. Otherwise it gets disposition 01 with count c-1.
- R8: An access to a way clears its armed count, so that a later eviction of that way behaves as in R6.
- R9: The results appear, with the output valid strobe high, exactly one cycle after a select request. The strobe is low after reset and in cycles with no request.
- R10: When a fill and an access hit the same way in the same cycle, the fill's count is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_req | input | 1 | Request a victim choice for the set |
| way_valid | input | WAYS | Per-way valid flags |
| way_single | input | WAYS | Per-way only-copy-on-chip flags |
| way_rank | input | WAYS*RW | Packed per-way LRU ranks |
| acc_en | input | 1 | Access (hit) event |
| acc_way | input | WW | Way that was accessed |
| fill_en | input | 1 | Fill event |
| fill_way | input | WW | Way being filled |
| fill_armed | input | 1 | Incoming line carries an armed count |
| fill_count | input | CW | Incoming remaining move count |
| vic_valid | output | 1 | Result valid strobe |
| vic_way | output | WW | Chosen way |
| vic_disp | output | 2 | 00 drop, 01 spill, 10 memory, 11 free way |
| vic_count | output | CW | Remaining move count sent with a spilled line |

## Verification
The assertions check several things on every cycle:
- the one-cycle strobe timing;
- that a free way always yields the free code;
- that a set holding a replicate never spills or writes back;
- that a set of only-copy lines never drops;
- that the outgoing count agrees with the disposition;
- that a fill overrides an access and an access disarms the counter.

Some behaviours only the bench scenarios can show. These are which exact way wins on LRU rank and index, and the full count life cycle of a line: armed by a fill, disarmed by a hit, then sent to memory or spilled.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  typedef enum logic [1:0] {
    DISP_DROP  = 2'b00,
    DISP_SPILL = 2'b01,
    DISP_MEM   = 2'b10,
    DISP_FREE  = 2'b11
  } disp_e;
endpackage

// File: rtl/vsel_pick.sv
// Finds the masked way with the highest rank; ties go to the lowest index.
module vsel_pick #(
  parameter int WAYS = 4,
  parameter int RW   = $clog2(WAYS),
  parameter int WW   = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]    mask,
  input  logic [WAYS*RW-1:0] ranks,
  output logic               found,
  output logic [WW-1:0]      way
);
  logic [RW-1:0] best;

  always_comb begin
    found = 1'b0;
    way   = '0;
    best  = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (mask[i] && (!found || ranks[i*RW +: RW] > best)) begin
        found = 1'b1;
        way   = WW'(i);
        best  = ranks[i*RW +: RW];
      end
    end
  end
endmodule

// File: rtl/vsel_recirc.sv
// Per-way move counters: a fill loads them; an access or an eviction disarms them.
module vsel_recirc #(
  parameter int WAYS = 4,
  parameter int WW   = $clog2(WAYS),
  parameter int CW   = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_en,
  input  logic [WW-1:0] acc_way,
  input  logic          fill_en,
  input  logic [WW-1:0] fill_way,
  input  logic          fill_armed,
  input  logic [CW-1:0] fill_count,
  input  logic          clr_en,
  input  logic [WW-1:0] clr_way,
  input  logic [WW-1:0] rd_way,
  output logic          rd_armed,
  output logic [CW-1:0] rd_count
);
  logic [WAYS-1:0] armed_q;
  logic [CW-1:0]   cnt_q [WAYS];
  logic            seen_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WAYS; i++) begin
      if (rst) begin
        armed_q[i] <= 1'b0;
        cnt_q[i]   <= '0;
      end else if (fill_en && fill_way == WW'(i)) begin
        armed_q[i] <= fill_armed;
        cnt_q[i]   <= fill_count;
      end else if ((acc_en && acc_way == WW'(i)) || (clr_en && clr_way == WW'(i))) begin
        armed_q[i] <= 1'b0;
        cnt_q[i]   <= '0;
      end
    end
  end

  assign rd_armed = armed_q[rd_way];
  assign rd_count = cnt_q[rd_way];

  assert_fill_wins_R10: assert property (@(posedge clk) disable iff (rst)
    seen_q && $past(fill_en && acc_en && fill_way == acc_way)
      |-> armed_q[$past(fill_way)] == $past(fill_armed));

  assert_access_disarms_R8: assert property (@(posedge clk) disable iff (rst)
    seen_q && $past(acc_en && !(fill_en && fill_way == acc_way))
      |-> !armed_q[$past(acc_way)]);
endmodule

// File: rtl/repl_victim_sel.sv
module repl_victim_sel #(
  parameter int WAYS     = 4,
  parameter int N_CHANCE = 1,
  parameter int RW       = $clog2(WAYS),
  parameter int WW       = $clog2(WAYS),
  parameter int CW       = $clog2(N_CHANCE + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_req,
  input  logic [WAYS-1:0]    way_valid,
  input  logic [WAYS-1:0]    way_single,
  input  logic [WAYS*RW-1:0] way_rank,
  input  logic               acc_en,
  input  logic [WW-1:0]      acc_way,
  input  logic               fill_en,
  input  logic [WW-1:0]      fill_way,
  input  logic               fill_armed,
  input  logic [CW-1:0]      fill_count,
  output logic               vic_valid,
  output logic [WW-1:0]      vic_way,
  output logic [1:0]         vic_disp,
  output logic [CW-1:0]      vic_count
);
  import vsel_pkg::*;

  localparam int NCLS = 3;  // 0: free way, 1: replicate, 2: only copy

  logic [NCLS-1:0][WAYS-1:0]    cls_mask;
  logic [NCLS-1:0][WAYS*RW-1:0] cls_rank;
  logic [NCLS-1:0]              cls_found;
  logic [WW-1:0]                cls_way [NCLS];

  assign cls_mask[0] = ~way_valid;
  assign cls_mask[1] = way_valid & ~way_single;
  assign cls_mask[2] = way_valid & way_single;
  assign cls_rank[0] = '0;
  assign cls_rank[1] = way_rank;
  assign cls_rank[2] = way_rank;

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    vsel_pick #(.WAYS(WAYS), .RW(RW), .WW(WW)) u_pick (
      .mask  (cls_mask[g]),
      .ranks (cls_rank[g]),
      .found (cls_found[g]),
      .way   (cls_way[g])
    );
  end

  logic          rd_armed;
  logic [CW-1:0] rd_count;
  logic [WW-1:0] nxt_way;
  disp_e         nxt_disp;
  logic [CW-1:0] nxt_count;
  logic          clr_en;

  vsel_recirc #(.WAYS(WAYS), .WW(WW), .CW(CW)) u_recirc (
    .clk        (clk),
    .rst        (rst),
    .acc_en     (acc_en),
    .acc_way    (acc_way),
    .fill_en    (fill_en),
    .fill_way   (fill_way),
    .fill_armed (fill_armed),
    .fill_count (fill_count),
    .clr_en     (clr_en),
    .clr_way    (nxt_way),
    .rd_way     (cls_way[2]),
    .rd_armed   (rd_armed),
    .rd_count   (rd_count)
  );

  always_comb begin
    nxt_count = '0;
    if (cls_found[0]) begin
      nxt_way  = cls_way[0];
      nxt_disp = DISP_FREE;
    end else if (cls_found[1]) begin
      nxt_way  = cls_way[1];
      nxt_disp = DISP_DROP;
    end else begin
      nxt_way = cls_way[2];
      if (!rd_armed) begin
        nxt_disp  = DISP_SPILL;
        nxt_count = CW'(N_CHANCE);
      end else if (rd_count <= CW'(1)) begin
        nxt_disp = DISP_MEM;
      end else begin
        nxt_disp  = DISP_SPILL;
        nxt_count = rd_count - CW'(1);
      end
    end
  end

  assign clr_en = sel_req && !cls_found[0];

  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q    <= 1'b0;
      vic_valid <= 1'b0;
      vic_way   <= '0;
      vic_disp  <= DISP_DROP;
      vic_count <= '0;
    end else begin
      seen_q    <= 1'b1;
      vic_valid <= sel_req;
      if (sel_req) begin
        vic_way   <= nxt_way;
        vic_disp  <= nxt_disp;
        vic_count <= nxt_count;
      end
    end
  end

  assert_strobe_lat_R9: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> vic_valid == $past(sel_req));

  assert_free_first_R1: assert property (@(posedge clk) disable iff (rst)
    seen_q && $past(sel_req && way_valid != '1) |-> vic_disp == DISP_FREE && vic_count == '0);

  assert_repl_dropped_R2: assert property (@(posedge clk) disable iff (rst)
    seen_q && $past(sel_req && way_valid == '1 && way_single != '1) |-> vic_disp == DISP_DROP);

  assert_single_kept_R4: assert property (@(posedge clk) disable iff (rst)
    seen_q && $past(sel_req && way_valid == '1 && way_single == '1)
      |-> vic_disp == DISP_SPILL || vic_disp == DISP_MEM);

  assert_mem_zero_R7: assert property (@(posedge clk) disable iff (rst)
    vic_valid && (vic_disp == DISP_MEM || vic_disp == DISP_DROP) |-> vic_count == '0);

  assert_spill_count_R6: assert property (@(posedge clk) disable iff (rst)
    vic_valid && vic_disp == DISP_SPILL |-> vic_count != '0 && vic_count <= CW'(N_CHANCE));
endmodule

// File: tb/repl_victim_sel_tb.sv
module repl_victim_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS = 4;
  localparam int WW   = 2;
  localparam int CW   = 1;

  logic            clk = 1'b0;
  logic            rst;
  logic            sel_req;
  logic [3:0]      way_valid, way_single;
  logic [7:0]      way_rank;
  logic            acc_en, fill_en, fill_armed;
  logic [WW-1:0]   acc_way, fill_way;
  logic [CW-1:0]   fill_count;
  logic            vic_valid;
  logic [WW-1:0]   vic_way;
  logic [1:0]      vic_disp;
  logic [CW-1:0]   vic_count;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  repl_victim_sel #(.WAYS(WAYS), .N_CHANCE(1)) u_dut (
    .clk(clk), .rst(rst), .sel_req(sel_req), .way_valid(way_valid),
    .way_single(way_single), .way_rank(way_rank), .acc_en(acc_en),
    .acc_way(acc_way), .fill_en(fill_en), .fill_way(fill_way),
    .fill_armed(fill_armed), .fill_count(fill_count), .vic_valid(vic_valid),
    .vic_way(vic_way), .vic_disp(vic_disp), .vic_count(vic_count)
  );

  // {valid, single, ranks{r3,r2,r1,r0}, exp_way, exp_disp, exp_count}
  localparam logic [20:0] TBL [8] = '{
    {4'b1111, 4'b0000, 8'b11_10_01_00, 2'd3, 2'b00, 1'b0},  // R3 R5
    {4'b1111, 4'b1000, 8'b11_10_01_00, 2'd2, 2'b00, 1'b0},  // R2 R5
    {4'b1111, 4'b1111, 8'b10_01_00_11, 2'd0, 2'b01, 1'b1},  // R4 R6
    {4'b1011, 4'b1111, 8'b11_10_01_00, 2'd2, 2'b11, 1'b0},  // R1
    {4'b0110, 4'b0000, 8'b11_10_01_00, 2'd0, 2'b11, 1'b0},  // R1
    {4'b1111, 4'b0101, 8'b00_10_01_11, 2'd1, 2'b00, 1'b0},  // R2 R3
    {4'b1111, 4'b1111, 8'b01_11_10_00, 2'd2, 2'b01, 1'b1},  // R4 R6
    {4'b1111, 4'b0001, 8'b10_01_00_11, 2'd3, 2'b00, 1'b0}   // R3
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_sel(input logic [3:0] v, input logic [3:0] s, input logic [7:0] r);
    @(negedge clk);
    way_valid = v; way_single = s; way_rank = r; sel_req = 1'b1;
    @(negedge clk);
    sel_req = 1'b0;
  endtask

  task automatic do_fill(input logic [WW-1:0] w, input logic a, input logic [CW-1:0] c,
                         input logic with_acc);
    @(negedge clk);
    fill_en = 1'b1; fill_way = w; fill_armed = a; fill_count = c;
    acc_en = with_acc; acc_way = w;
    @(negedge clk);
    fill_en = 1'b0; acc_en = 1'b0;
  endtask

  task automatic do_acc(input logic [WW-1:0] w);
    @(negedge clk);
    acc_en = 1'b1; acc_way = w;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; sel_req = 1'b0; way_valid = '0; way_single = '0; way_rank = '0;
    acc_en = 1'b0; acc_way = '0; fill_en = 1'b0; fill_way = '0;
    fill_armed = 1'b0; fill_count = '0;
    repeat (3) @(negedge clk);
    check("R9 reset strobe", int'(vic_valid), 0);
    check("R9 reset count", int'(vic_count), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      do_sel(TBL[i][20:17], TBL[i][16:13], TBL[i][12:5]);
      check("R9 strobe", int'(vic_valid), 1);
      check("R1-R4 way", int'(vic_way), int'(TBL[i][4:3]));
      check("R5 R6 disposition", int'(vic_disp), int'(TBL[i][2:1]));
      check("R6 count", int'(vic_count), int'(TBL[i][0]));
    end

    @(negedge clk);
    check("R9 idle strobe", int'(vic_valid), 0);

    // R7: armed count 1 arrives with a spilled line, next eviction writes back
    do_fill(2'd1, 1'b1, 1'b1, 1'b0);
    do_sel(4'b1111, 4'b1111, 8'b00_01_11_10);
    check("R7 way", int'(vic_way), 1);
    check("R7 disposition", int'(vic_disp), 2);
    check("R7 count", int'(vic_count), 0);

    // R8: an access disarms the counter, so the line spills again
    do_fill(2'd1, 1'b1, 1'b1, 1'b0);
    do_acc(2'd1);
    do_sel(4'b1111, 4'b1111, 8'b00_01_11_10);
    check("R8 disposition", int'(vic_disp), 1);
    check("R8 count", int'(vic_count), 1);

    // R10: fill and access in the same cycle, the fill is kept
    do_fill(2'd1, 1'b1, 1'b1, 1'b1);
    do_sel(4'b1111, 4'b1111, 8'b00_01_11_10);
    check("R10 disposition", int'(vic_disp), 2);

    // R1: a free way wins over an armed line
    do_fill(2'd2, 1'b1, 1'b1, 1'b0);
    do_sel(4'b0111, 4'b1111, 8'b00_11_01_10);
    check("R1 free way", int'(vic_way), 3);
    check("R1 free disposition", int'(vic_disp), 3);

    // R2: a replicate is picked over a higher-ranked armed line
    do_sel(4'b1111, 4'b1110, 8'b01_11_00_10);
    check("R2 way", int'(vic_way), 0);
    check("R5 drop", int'(vic_disp), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule